// File: doc/BRIEF.md
# Dual Coprime LFSR Timestamp

This block keeps a free-running time count without a wide binary adder. Two short shift-register sequence generators step together on every clock: a 7-bit one that cycles through 127 states and an 8-bit one that cycles through 255. Because 127 and 255 share no factor, the pair of states does not repeat until 32385 clocks have gone by. The critical path of the running count is one XOR gate per register, whatever the span of the count.

The raw states are presented at the outputs every cycle, so a consumer may store them and turn them into a number later. When a binary value is wanted on chip, a capture strobe freezes both states in the same clock. A decode path, which may take many cycles, then runs. It maps each frozen state to its position in its own cycle through a table generated at elaboration. It then combines the two positions by a Chinese-remainder search into the single count, and pulses a done flag.

Top module: `cts_timestamp`

## Requirements
- R1: While `rst` is high, both sequence registers take the value 1 (`lfsr_a_o` = 7'h01, `lfsr_b_o` = 8'h01), `count_o` is 0 and `done_o` is 0; this seed pair stands for count zero.
- R2: On every rising clock edge with `rst` low, register A shifts left and takes in as bit 0 the XOR of its bits 6 and 5, and register B shifts left and takes in the XOR of its bits 7, 5, 4 and 3; neither ever reaches the all-zero value.
- R3: Register A is back at its seed exactly 127 steps after reset and register B exactly 255 steps after reset; B is not at its seed after 127 steps.
- R4: `cap_i` high at a rising edge while no decode is running freezes the A and B states present before that edge, both from the same cycle.
- R5: The decoded `count_o` is the unique value below 32385 whose remainder by 127 is A's position and whose remainder by 255 is B's position, so it equals the number of steps since reset taken before the capture edge.
- R6: The count wraps modulo 32385: a capture after 32384 steps gives 32384, and a capture after 32385 + n steps gives n.
- R7: `done_o` is high for exactly one cycle per accepted capture, and `count_o` holds its value until the next done pulse.
- R8: `cap_i` while a decode is running is ignored: it produces no further done pulse and does not alter the result being decoded.
- R9: `done_o` rises at most 257 clock edges after the edge that accepted the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cap_i | input | 1 | Capture strobe |
| lfsr_a_o | output | 7 | Raw state of the 127-cycle register |
| lfsr_b_o | output | 8 | Raw state of the 255-cycle register |
| count_o | output | 15 | Most recent decoded binary count |
| done_o | output | 1 | One-cycle pulse when `count_o` has a new value |

## Verification
The bench captures at step zero, where both positions are zero and a decoder that mishandled the seed entry would return a non-zero count, and at multiples of one period, where one position is zero and an off-by-one table would give the wrong residue. It captures at 32384 and beyond 32385 steps, where a design that did not reduce modulo the product would overflow or return a huge value. A second strobe sent while a decode is still running would, in a design that re-latched, yield a second done pulse or a changed result. Latency is measured against the worst Chinese-remainder search so that a search that failed to terminate or stepped the wrong residue is caught.

// File: rtl/cts_pkg.sv
package cts_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_POS  = 2'd1,
        PH_CRT  = 2'd2
    } cts_phase_e;

    // One shift-left step of a Fibonacci register of width w.
    function automatic logic [15:0] lfsr_step(input logic [15:0] s,
                                              input logic [15:0] taps,
                                              input int          w);
        logic [15:0] mask;
        logic        fb;
        mask = (16'h1 << w) - 16'h1;
        fb   = ^(s & taps);
        return ((s << 1) | {15'd0, fb}) & mask;
    endfunction

    // State reached after n steps from seed; used to build position tables.
    function automatic logic [15:0] lfsr_nth(input logic [15:0] seed,
                                             input logic [15:0] taps,
                                             input int          w,
                                             input int          n);
        logic [15:0] s;
        s = seed;
        for (int k = 0; k < n; k++) begin
            s = lfsr_step(s, taps, w);
        end
        return s;
    endfunction

endpackage

// File: rtl/cts_lfsr.sv
module cts_lfsr #(
    parameter int           W    = 7,
    parameter logic [W-1:0] TAPS = 7'h60,
    parameter logic [W-1:0] SEED = 7'h01
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state_o
);
    typedef struct packed {
        logic [W-1:0] st;
    } lfsr_reg_t;

    lfsr_reg_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.st = W'(cts_pkg::lfsr_step(16'(r_q.st), 16'(TAPS), W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

    // R2: the register never locks up at zero
    a_r2_never_zero: assert property (@(posedge clk) disable iff (rst)
        r_q.st != '0);

    // R2: upper bits carry the previous lower bits after each step
    a_r2_shift_left: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> r_q.st[W-1:1] == $past(r_q.st[W-2:0]));

endmodule

// File: rtl/cts_pos_table.sv
module cts_pos_table #(
    parameter int           W      = 7,
    parameter logic [W-1:0] TAPS   = 7'h60,
    parameter logic [W-1:0] SEED   = 7'h01,
    parameter int           PERIOD = 127,
    localparam int          PW     = $clog2(PERIOD)
) (
    input  logic [W-1:0]  state_i,
    output logic [PW-1:0] pos_o
);
    logic [PW-1:0] term [PERIOD];

    for (genvar i = 0; i < PERIOD; i++) begin : g_entry
        localparam logic [W-1:0] ENTRY =
            W'(cts_pkg::lfsr_nth(16'(SEED), 16'(TAPS), W, i));
        assign term[i] = (state_i == ENTRY) ? PW'(i) : '0;
    end

    always_comb begin
        pos_o = '0;
        for (int i = 0; i < PERIOD; i++) begin
            pos_o = pos_o | term[i];
        end
    end

endmodule

// File: rtl/cts_decode.sv
module cts_decode #(
    parameter int            WA     = 7,
    parameter logic [WA-1:0] TAPS_A = 7'h60,
    parameter logic [WA-1:0] SEED_A = 7'h01,
    parameter int            PA     = 127,
    parameter int            WB     = 8,
    parameter logic [WB-1:0] TAPS_B = 8'hB8,
    parameter logic [WB-1:0] SEED_B = 8'h01,
    parameter int            PB     = 255,
    localparam int           PAW    = $clog2(PA),
    localparam int           PBW    = $clog2(PB),
    localparam int           CW     = $clog2(PA * PB),
    localparam int           SW     = PBW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_i,
    input  logic [WA-1:0] a_i,
    input  logic [WB-1:0] b_i,
    output logic [CW-1:0] count_o,
    output logic          done_o
);
    import cts_pkg::*;

    typedef struct packed {
        cts_phase_e     ph;
        logic [WA-1:0]  lat_a;
        logic [WB-1:0]  lat_b;
        logic [PAW-1:0] pos_a;
        logic [PBW-1:0] pos_b;
        logic [CW-1:0]  acc;
        logic [PBW-1:0] res;
        logic [CW-1:0]  count;
        logic           done;
    } dec_reg_t;

    dec_reg_t r_q, r_d;
    logic [PAW-1:0] tpos_a;
    logic [PBW-1:0] tpos_b;
    logic [SW-1:0]  sum;

    cts_pos_table #(.W(WA), .TAPS(TAPS_A), .SEED(SEED_A), .PERIOD(PA)) u_tab_a (
        .state_i (r_q.lat_a),
        .pos_o   (tpos_a)
    );

    cts_pos_table #(.W(WB), .TAPS(TAPS_B), .SEED(SEED_B), .PERIOD(PB)) u_tab_b (
        .state_i (r_q.lat_b),
        .pos_o   (tpos_b)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        sum      = SW'(r_q.res) + SW'(PA);
        case (r_q.ph)
            PH_IDLE: begin
                if (cap_i) begin
                    r_d.lat_a = a_i;
                    r_d.lat_b = b_i;
                    r_d.ph    = PH_POS;
                end
            end
            PH_POS: begin
                r_d.pos_a = tpos_a;
                r_d.pos_b = tpos_b;
                r_d.acc   = CW'(tpos_a);
                r_d.res   = PBW'(tpos_a);
                r_d.ph    = PH_CRT;
            end
            PH_CRT: begin
                if (r_q.res == r_q.pos_b) begin
                    r_d.count = r_q.acc;
                    r_d.done  = 1'b1;
                    r_d.ph    = PH_IDLE;
                end else begin
                    r_d.acc = r_q.acc + CW'(PA);
                    r_d.res = (sum >= SW'(PB)) ? PBW'(sum - SW'(PB)) : PBW'(sum);
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.ph <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign count_o = r_q.count;
    assign done_o  = r_q.done;

    // R5: during the search the accumulator keeps A's residue
    a_r5_acc_mod_a: assert property (@(posedge clk) disable iff (rst)
        r_q.ph == PH_CRT |-> (32'(r_q.acc) % PA) == 32'(r_q.pos_a));

    // R5: the running residue tracks the accumulator modulo B's period
    a_r5_res_tracks: assert property (@(posedge clk) disable iff (rst)
        r_q.ph == PH_CRT |-> (32'(r_q.acc) % PB) == 32'(r_q.res));

    // R5: table positions lie inside each cycle
    a_r5_pos_range: assert property (@(posedge clk) disable iff (rst)
        r_q.ph == PH_CRT |-> (32'(r_q.pos_a) < PA) && (32'(r_q.pos_b) < PB));

    // R6: a finished count is below the combined period
    a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
        r_q.done |-> 32'(r_q.count) < PA * PB);

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        r_q.done |=> !r_q.done);

    // R8: frozen states do not move while a decode runs
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
        r_q.ph != PH_IDLE |=> $stable(r_q.lat_a) && $stable(r_q.lat_b));

endmodule

// File: rtl/cts_timestamp.sv
module cts_timestamp #(
    parameter int              A_W    = 7,
    parameter logic [A_W-1:0]  A_TAPS = 7'h60,
    parameter logic [A_W-1:0]  A_SEED = 7'h01,
    parameter int              A_LEN  = 127,
    parameter int              B_W    = 8,
    parameter logic [B_W-1:0]  B_TAPS = 8'hB8,
    parameter logic [B_W-1:0]  B_SEED = 8'h01,
    parameter int              B_LEN  = 255,
    localparam int             CNT_W  = $clog2(A_LEN * B_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_i,
    output logic [A_W-1:0]   lfsr_a_o,
    output logic [B_W-1:0]   lfsr_b_o,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    cts_lfsr #(.W(A_W), .TAPS(A_TAPS), .SEED(A_SEED)) u_lfsr_a (
        .clk     (clk),
        .rst     (rst),
        .state_o (lfsr_a_o)
    );

    cts_lfsr #(.W(B_W), .TAPS(B_TAPS), .SEED(B_SEED)) u_lfsr_b (
        .clk     (clk),
        .rst     (rst),
        .state_o (lfsr_b_o)
    );

    cts_decode #(
        .WA(A_W), .TAPS_A(A_TAPS), .SEED_A(A_SEED), .PA(A_LEN),
        .WB(B_W), .TAPS_B(B_TAPS), .SEED_B(B_SEED), .PB(B_LEN)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap_i),
        .a_i     (lfsr_a_o),
        .b_i     (lfsr_b_o),
        .count_o (count_o),
        .done_o  (done_o)
    );

endmodule

// File: tb/cts_timestamp_bench.sv
module cts_timestamp_bench;
    localparam int SPAN = 127 * 255;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_i = 1'b0;
    logic [6:0]  lfsr_a_o;
    logic [7:0]  lfsr_b_o;
    logic [14:0] count_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;
    int cyc    = 0;
    int exp_q[$];
    int cap_cyc_q[$];
    logic [6:0] ma = 7'h01;
    logic [7:0] mb = 8'h01;
    logic       prev_done = 1'b0;
    int         held = 0;

    always #4 clk = ~clk;

    cts_timestamp u_cts_timestamp (
        .clk      (clk),
        .rst      (rst),
        .cap_i    (cap_i),
        .lfsr_a_o (lfsr_a_o),
        .lfsr_b_o (lfsr_b_o),
        .count_o  (count_o),
        .done_o   (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Independent reference of the two sequences and step count
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            ticks <= ticks + 1;
            ma    <= {ma[5:0], ma[6] ^ ma[5]};
            mb    <= {mb[6:0], mb[7] ^ mb[5] ^ mb[4] ^ mb[3]};
        end
    end

    // Monitor: raw state compare, period checks, scoreboard pops
    always @(negedge clk) begin
        if (!rst) begin
            if (ticks % 97 == 0) begin
                chk(lfsr_a_o == ma, "R2 state A", lfsr_a_o, ma);
                chk(lfsr_b_o == mb, "R2 state B", lfsr_b_o, mb);
            end
            if (ticks == 127) begin
                chk(lfsr_a_o == 7'h01, "R3 A period", lfsr_a_o, 1);
                chk(lfsr_b_o != 8'h01, "R3 B not early", lfsr_b_o, -1);
            end
            if (ticks == 255) chk(lfsr_b_o == 8'h01, "R3 B period", lfsr_b_o, 1);
            if (prev_done) begin
                chk(!done_o, "R7 done one cycle", done_o, 0);
                chk(count_o == 15'(held), "R7 count held", count_o, held);
            end
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 spurious done", count_o, -1);
                end else begin
                    int e;
                    int c0;
                    e  = exp_q.pop_front();
                    c0 = cap_cyc_q.pop_front();
                    chk(count_o == 15'(e), "R4 R5 R6 count", count_o, e);
                    chk(cyc - c0 <= 258, "R9 latency", cyc - c0, 258);
                end
                held = count_o;
            end
            prev_done = done_o;
        end
    end

    task automatic do_cap();
        exp_q.push_back(ticks % SPAN);
        cap_cyc_q.push_back(cyc);
        cap_i = 1'b1;
        @(negedge clk);
        cap_i = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cap_at(input int target);
        while (ticks < target) @(negedge clk);
        do_cap();
        wait_empty();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(lfsr_a_o == 7'h01, "R1 seed A", lfsr_a_o, 1);
        chk(lfsr_b_o == 8'h01, "R1 seed B", lfsr_b_o, 1);
        chk(count_o == 0, "R1 count", count_o, 0);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        rst = 1'b0;
        do_cap();              // step zero
        wait_empty();
        cap_at(300);
        cap_at(635);           // A position zero
        // R8: second strobe while the decode for 1020 runs
        while (ticks < 1020) @(negedge clk);
        do_cap();
        cap_i = 1'b1;
        @(negedge clk);
        cap_i = 1'b0;
        wait_empty();
        repeat (300) @(negedge clk);
        cap_at(4001);
        cap_at(16256);
        cap_at(32384);         // R6 last value before wrap
        cap_at(32770);         // R6 wraps to 385
        cap_at(2 * SPAN);      // R6 back to zero
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule